// File: doc/BRIEF.md
# Global-History XOR-Indexed Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one shift register of the most recent branch outcomes, shared by every branch. To pick an entry in a shared table of saturating counters, it XORs a field of the fetch PC with that history. The top bit of the chosen counter gives the predicted direction. Because all branches feed the same history, the outcome of an earlier branch steers the counter that a later, correlated branch uses.

The fetch stage drives the PC and reads back two things in the same cycle: the direction and the table index that was used. The index travels down the pipeline with the branch. When the branch resolves, the back end returns that saved index together with the real outcome on the update port. That trains the counter that made the prediction and shifts the outcome into the history. Both changes take effect at the next rising clock edge.

Top module: `hist_xor_predictor`

## Requirements
- R1: After synchronous active-low reset, the history register is all zeros and every counter holds the weakly not-taken value (binary 01 for 2-bit counters), so every PC is predicted not-taken.
- R2: `pred_index` equals PC bits [ALIGN_LSB+PC_BITS-1 : ALIGN_LSB] XOR the history register. Its width is max(PC_BITS, HIST_W), and the narrower operand is zero-extended. With the defaults this is pred_pc[9:2] XOR {2'b00, history[5:0]}.
- R3: `pred_taken` is the most significant bit of the counter selected by `pred_index` (counter value 2 or 3 for 2-bit counters means taken).
- R4: An update with outcome taken increments the counter at `upd_index` by one, and the counter saturates at its maximum (3).
- R5: An update with outcome not-taken decrements the counter at `upd_index` by one, and the counter saturates at zero.
- R6: An update shifts its outcome into history bit 0, moves every other bit up by one and drops the oldest bit.
- R7: While `upd_valid` is low, `upd_index` and `upd_taken` have no effect: neither the history nor any counter changes.
- R8: Training touches only the counter named by `upd_index`, even when the current history and PC would select another entry. All other counters keep their values.
- R9: The prediction outputs are combinational from `pred_pc` and the state after the last clock edge. An update takes effect only from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | PC_W | Fetch PC to be predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_index | output | max(PC_BITS,HIST_W) | Table index used; carried with the branch |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_index | input | max(PC_BITS,HIST_W) | Saved index from the prediction |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench drives both counter ends past their limits. At the top, a table that wraps would turn a strongly taken counter into not-taken after one extra taken update. At the bottom, underflow would make a single taken update predict taken. It reads the history back through `pred_index` with a zero PC field, which exposes a shift in the wrong direction or an outcome inserted at the wrong end. It presents `upd_taken` and `upd_index` with `upd_valid` low, and trains one entry while the PC points at another. A design that ignored the valid bit, or recomputed the index from the new history, would corrupt a neighbouring counter that the bench then reads. A long random run with delayed indices compares every output against a behavioural model on every cycle.

// File: rtl/ghx_pkg.sv
// Package: shared helpers for the global-history XOR predictor.
// Assumes: used only at elaboration time for width arithmetic.
package ghx_pkg;

    // Larger of two widths; the table index takes this width.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Direction encoding used on all outcome and prediction signals.
    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_e;

endpackage

// File: rtl/history_shreg.sv
// Module: global outcome history shift register.
// Does: holds the last HIST_W resolved outcomes, newest in bit 0.
// Assumes: HIST_W >= 2; one update at most per cycle.
module history_shreg #(
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_in,
    output logic [HIST_W-1:0] hist
);

    // Shift the new outcome in at the bottom on every valid update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (shift_en)
            hist <= {hist[HIST_W-2:0], shift_in};
    end

    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist[0] == $past(shift_in)) &&
                     (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));

    assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist));

endmodule

// File: rtl/xor_index_hash.sv
// Module: forms the counter-table index from PC bits and history.
// Does: extracts PC_BITS bits above the alignment bits, zero-extends
//       whichever operand is narrower, and XORs them.
// Assumes: ALIGN_LSB + PC_BITS <= PC_W.
module xor_index_hash #(
    parameter int PC_W      = 32,
    parameter int PC_BITS   = 8,
    parameter int HIST_W    = 6,
    parameter int ALIGN_LSB = 2,
    localparam int IDX_W    = ghx_pkg::imax(PC_BITS, HIST_W)
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  index
);

    logic [PC_BITS-1:0] pc_field;
    logic [IDX_W-1:0]   pc_ext;
    logic [IDX_W-1:0]   hist_ext;

    // Take the PC field just above the instruction-alignment bits.
    assign pc_field = pc[ALIGN_LSB +: PC_BITS];

    // Collect the PC bits that take no part in the hash.
    generate
        if (ALIGN_LSB > 0) begin : g_lo
            logic [ALIGN_LSB-1:0] pc_lo_unused;
            assign pc_lo_unused = pc[ALIGN_LSB-1:0];
        end
        if (ALIGN_LSB + PC_BITS < PC_W) begin : g_hi
            logic [PC_W-ALIGN_LSB-PC_BITS-1:0] pc_hi_unused;
            assign pc_hi_unused = pc[PC_W-1:ALIGN_LSB+PC_BITS];
        end
    endgenerate

    // Zero-extend the narrower operand to the index width.
    generate
        if (PC_BITS == HIST_W) begin : g_same
            assign pc_ext   = pc_field;
            assign hist_ext = hist;
        end else if (PC_BITS > HIST_W) begin : g_pc_wide
            assign pc_ext   = pc_field;
            assign hist_ext = {{(IDX_W-HIST_W){1'b0}}, hist};
        end else begin : g_hist_wide
            assign pc_ext   = {{(IDX_W-PC_BITS){1'b0}}, pc_field};
            assign hist_ext = hist;
        end
    endgenerate

    // Combine the two operands into the table index.
    assign index = pc_ext ^ hist_ext;

endmodule

// File: rtl/sat_ctr_cell.sv
// Module: one n-bit up/down saturating counter.
// Does: steps up on a taken outcome and down on a not-taken one,
//       holding at the ends; exposes only its direction bit.
// Assumes: CTR_W >= 2; resets to the weakly not-taken value.
module sat_ctr_cell #(
    parameter int CTR_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  logic step_up,
    output logic dir_bit
);

    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_MIN  = '0;
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

    logic [CTR_W-1:0] value;

    // Saturating step toward the resolved outcome.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= CTR_INIT;
        else if (step_en && step_up && (value != CTR_MAX))
            value <= value + CTR_W'(1);
        else if (step_en && !step_up && (value != CTR_MIN))
            value <= value - CTR_W'(1);
    end

    // The most significant bit gives the predicted direction.
    assign dir_bit = value[CTR_W-1];

    assert_ctr_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && value != CTR_MAX) |=> value == $past(value) + CTR_W'(1));

    assert_ctr_sat_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && value == CTR_MAX) |=> value == CTR_MAX);

    assert_ctr_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && value != CTR_MIN) |=> value == $past(value) - CTR_W'(1));

    assert_ctr_sat_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && value == CTR_MIN) |=> value == CTR_MIN);

    assert_ctr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(value));

endmodule

// File: rtl/ctr_table.sv
// Module: shared table of saturating counters.
// Does: one read port (direction bit at rd_index) and one training
//       port (wr_en, wr_index, wr_up) per cycle.
// Assumes: the read sees state from before the current edge.
module ctr_table #(
    parameter int IDX_W = 8,
    parameter int CTR_W = 2,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_index,
    output logic             rd_dir,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_index,
    input  logic             wr_up
);

    logic [DEPTH-1:0] dir_vec;
    logic [DEPTH-1:0] step_vec;

    // One counter per entry, each enabled by its own decoded select.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            assign step_vec[i] = wr_en && (wr_index == IDX_W'(i));
            sat_ctr_cell #(.CTR_W(CTR_W)) cell_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .step_en (step_vec[i]),
                .step_up (wr_up),
                .dir_bit (dir_vec[i])
            );
        end
    endgenerate

    // Select the direction bit of the addressed entry.
    assign rd_dir = dir_vec[rd_index];

    assert_one_entry_trained_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_vec) && (wr_en || step_vec == '0));

endmodule

// File: rtl/hist_xor_predictor.sv
// Module: top of the global-history XOR-indexed direction predictor.
// Does: hashes the fetch PC with global history to pick a counter,
//       reports its direction and index; trains the counter at the
//       returned index and shifts the outcome into history.
// Assumes: the update carries the index produced at prediction time.
module hist_xor_predictor #(
    parameter int PC_W      = 32,
    parameter int PC_BITS   = 8,
    parameter int HIST_W    = 6,
    parameter int CTR_W     = 2,
    parameter int ALIGN_LSB = 2,
    localparam int IDX_W    = ghx_pkg::imax(PC_BITS, HIST_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_index,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_index,
    input  logic             upd_taken
);

    logic [HIST_W-1:0] ghist;

    // Shared outcome history.
    history_shreg #(.HIST_W(HIST_W)) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .shift_in (upd_taken),
        .hist     (ghist)
    );

    // Index formation from PC field and history.
    xor_index_hash #(
        .PC_W      (PC_W),
        .PC_BITS   (PC_BITS),
        .HIST_W    (HIST_W),
        .ALIGN_LSB (ALIGN_LSB)
    ) hash_i (
        .pc    (pred_pc),
        .hist  (ghist),
        .index (pred_index)
    );

    // Counter storage and training.
    ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_index (pred_index),
        .rd_dir   (pred_taken),
        .wr_en    (upd_valid),
        .wr_index (upd_index),
        .wr_up    (upd_taken == ghx_pkg::DIR_TAKEN)
    );

    assert_pred_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid && $stable(pred_pc)) |=> ($stable(pred_pc) -> $stable(pred_taken)));

endmodule

// File: tb/hist_xor_predictor_tb_top.sv
`timescale 1ns/1ps
module hist_xor_predictor_tb_top;

    localparam int PC_W  = 32;
    localparam int PB    = 8;
    localparam int HW    = 6;
    localparam int CW    = 2;
    localparam int AL    = 2;
    localparam int IW    = (PB > HW) ? PB : HW;
    localparam int TBL   = 1 << IW;
    localparam int CMAX  = (1 << CW) - 1;
    localparam int CINIT = (1 << (CW - 1)) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken;
    logic [IW-1:0]   pred_index;
    logic            upd_valid = 1'b0;
    logic [IW-1:0]   upd_index = '0;
    logic            upd_taken = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int mctr[TBL];
    int mhist = 0;
    int idx_q[$];

    always #2 clk = ~clk;

    hist_xor_predictor #(
        .PC_W(PC_W), .PC_BITS(PB), .HIST_W(HW), .CTR_W(CW), .ALIGN_LSB(AL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_index(pred_index), .upd_valid(upd_valid), .upd_index(upd_index),
        .upd_taken(upd_taken)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int m_index(input logic [PC_W-1:0] pc);
        return ((int'(pc >> AL)) & ((1 << PB) - 1)) ^ mhist;
    endfunction

    // PC whose hash lands on entry i under the current model history.
    function automatic logic [PC_W-1:0] pc_for(input int i);
        return PC_W'(((i ^ mhist) & ((1 << PB) - 1)) << AL);
    endfunction

    // One cycle: drive, compare against the model, then advance the model.
    task automatic step(input logic [PC_W-1:0] pc, input bit v,
                        input int idx, input bit tk, input string tag);
        int ei;
        @(negedge clk);
        pred_pc   = pc;
        upd_valid = v;
        upd_index = IW'(idx);
        upd_taken = tk;
        #1;
        ei = m_index(pc);
        chk({tag, " R2 index"}, int'(pred_index), ei);
        chk({tag, " R3 taken"}, int'(pred_taken), int'(mctr[ei] > CINIT));
        if (v) begin
            if (tk && mctr[idx] < CMAX) mctr[idx]++;
            if (!tk && mctr[idx] > 0) mctr[idx]--;
            mhist = ((mhist << 1) | int'(tk)) & ((1 << HW) - 1);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        foreach (mctr[i]) mctr[i] = CINIT;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every sample predicts not-taken, history zero.
        for (int k = 0; k < 6; k++) begin
            step(PC_W'(k * 1236 + 4), 1'b0, 0, 1'b0, "R1");
            chk("R1 not-taken after reset", int'(pred_taken), 0);
        end
        step('0, 1'b0, 0, 1'b0, "R1");
        chk("R1 history zero", int'(pred_index), 0);

        // R4: five taken updates on entry 9 saturate at max.
        for (int k = 0; k < 5; k++) step(pc_for(9), 1'b1, 9, 1'b1, "R4");
        step(pc_for(9), 1'b1, 9, 1'b0, "R4");
        step(pc_for(9), 1'b0, 0, 1'b0, "R4");
        chk("R4 saturated high still taken", int'(pred_taken), 1);
        step(pc_for(9), 1'b1, 9, 1'b0, "R4");
        step(pc_for(9), 1'b0, 0, 1'b0, "R4");
        chk("R4 after two decrements", int'(pred_taken), 0);

        // R5: three not-taken updates on entry 20 saturate at zero.
        for (int k = 0; k < 3; k++) step(pc_for(20), 1'b1, 20, 1'b0, "R5");
        step(pc_for(20), 1'b1, 20, 1'b1, "R5");
        step(pc_for(20), 1'b0, 0, 1'b0, "R5");
        chk("R5 saturated low then one up", int'(pred_taken), 0);

        // R6: history is visible in the index with a zero PC field.
        step('0, 1'b1, 40, 1'b1, "R6");
        step('0, 1'b1, 40, 1'b0, "R6");
        step('0, 1'b1, 40, 1'b1, "R6");
        step('0, 1'b0, 0, 1'b0, "R6");
        chk("R6 history shift", int'(pred_index), mhist);
        chk("R6 newest bits", int'(pred_index) & 7, 5);

        // R7: updates with valid low change nothing.
        for (int k = 0; k < 4; k++) step(pc_for(9), 1'b0, 9, 1'b1, "R7");
        step(pc_for(9), 1'b0, 0, 1'b0, "R7");
        chk("R7 counter unchanged", int'(pred_taken), 0);
        chk("R7 history unchanged", int'(pred_index), 9);

        // R8: train entry 33 twice while the PC selects entry 34.
        step(pc_for(34), 1'b1, 33, 1'b1, "R8");
        step(pc_for(34), 1'b1, 33, 1'b1, "R8");
        step(pc_for(34), 1'b0, 0, 1'b0, "R8");
        chk("R8 neighbour untouched", int'(pred_taken), 0);
        step(pc_for(33), 1'b0, 0, 1'b0, "R8");
        chk("R8 trained entry taken", int'(pred_taken), 1);

        // R9: an update in the same cycle leaves that cycle's prediction alone.
        step(pc_for(50), 1'b1, 50, 1'b1, "R9");
        step(pc_for(50), 1'b1, 50, 1'b1, "R9");
        step(pc_for(50), 1'b0, 0, 1'b0, "R9");
        chk("R9 visible after edge", int'(pred_taken), 1);

        // Random run with indices returned a few cycles late.
        for (int k = 0; k < 3000; k++) begin
            logic [PC_W-1:0] pc;
            bit v;
            int ui;
            pc = PC_W'($urandom_range(0, 255) * 4 + ($urandom_range(0, 3) << 12));
            idx_q.push_back(m_index(pc));
            v = (idx_q.size() > 3) && ($urandom_range(0, 3) != 0);
            ui = v ? idx_q.pop_front() : int'($urandom_range(0, TBL - 1));
            step(pc, v, ui, 1'($urandom_range(0, 99) < 65), "R2R3 random");
        end

        summary();
        $finish;
    end

endmodule